// File: doc/BRIEF.md
# Joint Translation Buffer with Per-Entry Page Size

This block translates 32-bit virtual addresses into 36-bit physical addresses for both the instruction side and the data side of a processor, from one fully associative array. Every entry describes a pair of neighbouring virtual pages: an even page and an odd page. Each page of the pair has its own frame number, 3-bit cache attribute, dirty bit and valid bit. A per-entry size mask sets the page size anywhere from 4KB to 16MB in steps of four. That mask decides which virtual page bits take part in the tag compare, and it decides which virtual address bit picks the even or the odd half of the pair.

The two fetch/access sides share one lookup path. A data request takes the path ahead of an instruction request in the same cycle. Every result is registered, so it appears one clock after the request. That timing lines up the physical frame with a synchronous cache array read started in the same cycle as the request. A maintenance port lets control software write a whole entry by index, read a whole entry by index, or probe for the entry that matches a given tag.

Top module: `jtlb`

## Requirements
- R1: A synchronous active-high reset clears every entry to all zeros and drives every registered output to zero. An entry that reset has cleared has both halves invalid.
- R2: The entry word is 98 bits, packed from the most significant bit down as follows. Tag fields: VPN2 [97:79] (virtual address bits 31:13), size mask [78:67], ASID [66:59], global [58]. Then the odd half [57:29] and the even half [28:0]. Each half holds, from the top down: frame [28:5], attribute [4:2], dirty [1], valid [0]. An entry matches a lookup when the unmasked VPN2 bits are equal and, in addition, either its global bit is set or its ASID equals `cur_asid`.
- R3: The legal size masks are 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF, giving 4KB to 16MB pages. Mask bit i removes VPN2 bit i from the compare. With 2k mask bits set, virtual address bit 12+2k selects the odd half (1) or the even half (0).
- R4: The physical address takes the low 12+2k bits from the virtual address and all higher bits from the selected frame placed at bit 12.
- R5: When several entries match, the lowest index supplies the translation, and probe reports that same index.
- R6: `res_miss` is set when no entry matches. `res_inval` is set when the selected half has its valid bit clear.
- R7: `res_modf` is set for a data store to a valid half whose dirty bit is clear. At most one of the three fault flags is high at a time. An instruction result never carries a modified fault.
- R8: When both sides request in the same cycle, the data side wins: `d_gnt`=1 and `i_gnt`=0. `res_side` then reports 1 for data and 0 for instruction.
- R9: The op codes are 1 = write, 2 = read and 3 = probe. Write stores `sw_wdata` at `sw_index`. Read returns the stored word on `sw_rdata` one cycle later. Every op pulses `sw_ack` one cycle later.
- R10: Probe compares the VPN2 and ASID fields of `sw_wdata` against all entries. It returns the matching index on `sw_pidx`, or sets `sw_pnf` when nothing matches.
- R11: A lookup result appears exactly one cycle after its request, with `res_valid` high. A lookup issued in the cycle after a write sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_req | input | 1 | Instruction-side lookup request |
| i_va | input | 32 | Instruction-side virtual address |
| i_gnt | output | 1 | Instruction request granted this cycle |
| d_req | input | 1 | Data-side lookup request |
| d_va | input | 32 | Data-side virtual address |
| d_store | input | 1 | Data access is a store |
| d_gnt | output | 1 | Data request granted this cycle |
| cur_asid | input | 8 | Current address-space ID |
| res_valid | output | 1 | Lookup result valid |
| res_side | output | 1 | 1 = data result, 0 = instruction result |
| res_miss | output | 1 | No entry matched |
| res_inval | output | 1 | Matched half is invalid |
| res_modf | output | 1 | Store to a clean half |
| res_attr | output | 3 | Cache attribute of the selected half |
| res_pa | output | 36 | Physical address |
| sw_op | input | 2 | Maintenance op: 0 idle, 1 write, 2 read, 3 probe |
| sw_index | input | 6 | Entry index for write and read |
| sw_wdata | input | 98 | Entry word to write, or probe tag |
| sw_ack | output | 1 | Maintenance op done |
| sw_rdata | output | 98 | Entry word returned by read |
| sw_pnf | output | 1 | Probe found no match |
| sw_pidx | output | 6 | Index returned by probe |

## Verification
The assertions watch the arbitration and timing rules on every cycle:
- the two grants are never high together, and a data request always takes the path;
- a result follows every request by exactly one cycle and carries the right side bit;
- the fault flags stay mutually exclusive, and instruction results never carry a modified fault;
- the page offset passes straight through to the physical address;
- every maintenance op is acknowledged.

Whether the masked compare, the choice of odd or even half, the frame splice at each page size, the lowest-index priority and the probe index are correct depends on table contents. Only the bench's scenarios can show these, using entries it has written itself.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int PG_W   = 12;
  localparam int MASK_W = 12;
  localparam int ASID_W = 8;
  localparam int ATTR_W = 3;
  localparam int VPN2_W = VA_W - PG_W - 1;
  localparam int PFN_W  = PA_W - PG_W;

  typedef struct packed {
    logic [PFN_W-1:0]  pfn;
    logic [ATTR_W-1:0] attr;
    logic              dirty;
    logic              valid;
  } tlb_half_t;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [MASK_W-1:0] mask;
    logic [ASID_W-1:0] asid;
    logic              gbl;
    tlb_half_t         odd;
    tlb_half_t         even;
  } tlb_entry_t;

  localparam int ENT_W = $bits(tlb_entry_t);

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_WRITE = 2'd1,
    SW_READ  = 2'd2,
    SW_PROBE = 2'd3
  } sw_op_e;

  // Walk the contiguous run of mask ones from the bottom; the first clear bit
  // marks the address bit that chooses between the two halves.
  function automatic logic odd_select(input logic [VA_W-1:0] va,
                                      input logic [MASK_W-1:0] mask);
    logic sel;
    logic stop;
    sel  = va[PG_W];
    stop = 1'b0;
    for (int j = 0; j < MASK_W; j++) begin
      if (!stop) begin
        if (!mask[j]) stop = 1'b1;
        else          sel  = va[PG_W + j + 1];
      end
    end
    return sel;
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [VA_W-1:0] va,
                                              input logic [MASK_W-1:0] mask);
    logic [PA_W-1:0] keep;
    logic [PA_W-1:0] vext;
    keep = {{(PA_W-MASK_W-PG_W){1'b0}}, mask, {PG_W{1'b1}}};
    vext = {{(PA_W-VA_W){1'b0}}, va};
    return ({pfn, {PG_W{1'b0}}} & ~keep) | (vext & keep);
  endfunction
endpackage

// File: rtl/tlb_arb.sv
module tlb_arb
  import tlb_pkg::*;
(
  input  logic            i_req,
  input  logic [VA_W-1:0] i_va,
  input  logic            d_req,
  input  logic [VA_W-1:0] d_va,
  input  logic            d_store,
  output logic            look_valid,
  output logic            look_side,
  output logic [VA_W-1:0] look_va,
  output logic            look_store,
  output logic            i_gnt,
  output logic            d_gnt
);
  // Data accesses stall the pipeline harder than fetches, so they go first.
  always_comb begin
    d_gnt      = d_req;
    i_gnt      = i_req && !d_req;
    look_valid = i_req || d_req;
    look_side  = d_req;
    look_va    = d_req ? d_va : i_va;
    look_store = d_req && d_store;
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = 48,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  tlb_entry_t       wdata,
  output tlb_entry_t       ent [ENTRIES]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else if (we) begin
      ent[widx] <= wdata;
    end
  end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48
) (
  input  tlb_entry_t          ent [ENTRIES],
  input  logic [VPN2_W-1:0]   vpn2,
  input  logic [ASID_W-1:0]   asid,
  output logic [ENTRIES-1:0]  hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [VPN2_W-1:0] care;
    logic              tag_eq;
    logic              space_ok;
    assign care     = ~{{(VPN2_W-MASK_W){1'b0}}, ent[g].mask};
    assign tag_eq   = ((vpn2 ^ ent[g].vpn2) & care) == '0;
    assign space_ok = ent[g].gbl || (ent[g].asid == asid);
    assign hit[g]   = tag_eq && space_ok;
  end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
  parameter  int N     = 48,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             found
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/jtlb.sv
module jtlb
  import tlb_pkg::*;
#(
  parameter  int ENTRIES = 48,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               i_req,
  input  logic [VA_W-1:0]    i_va,
  output logic               i_gnt,
  input  logic               d_req,
  input  logic [VA_W-1:0]    d_va,
  input  logic               d_store,
  output logic               d_gnt,
  input  logic [ASID_W-1:0]  cur_asid,
  output logic               res_valid,
  output logic               res_side,
  output logic               res_miss,
  output logic               res_inval,
  output logic               res_modf,
  output logic [ATTR_W-1:0]  res_attr,
  output logic [PA_W-1:0]    res_pa,
  input  logic [1:0]         sw_op,
  input  logic [IDX_W-1:0]   sw_index,
  input  logic [ENT_W-1:0]   sw_wdata,
  output logic               sw_ack,
  output logic [ENT_W-1:0]   sw_rdata,
  output logic               sw_pnf,
  output logic [IDX_W-1:0]   sw_pidx
);
  sw_op_e      op;
  tlb_entry_t  wr_ent;
  logic        in_range;
  assign op       = sw_op_e'(sw_op);
  assign wr_ent   = tlb_entry_t'(sw_wdata);
  assign in_range = {1'b0, sw_index} < (IDX_W + 1)'(ENTRIES);

  logic            look_valid, look_side, look_store;
  logic [VA_W-1:0] look_va;

  tlb_arb u_arb (
    .i_req(i_req), .i_va(i_va), .d_req(d_req), .d_va(d_va), .d_store(d_store),
    .look_valid(look_valid), .look_side(look_side), .look_va(look_va),
    .look_store(look_store), .i_gnt(i_gnt), .d_gnt(d_gnt)
  );

  tlb_entry_t ent [ENTRIES];

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst(rst), .we((op == SW_WRITE) && in_range),
    .widx(sw_index), .wdata(wr_ent), .ent(ent)
  );

  logic [ENTRIES-1:0] l_hit, p_hit;
  logic [IDX_W-1:0]   l_idx, p_idx;
  logic               l_found, p_found;

  tlb_match #(.ENTRIES(ENTRIES)) u_lmatch (
    .ent(ent), .vpn2(look_va[VA_W-1:PG_W+1]), .asid(cur_asid), .hit(l_hit)
  );
  tlb_match #(.ENTRIES(ENTRIES)) u_pmatch (
    .ent(ent), .vpn2(wr_ent.vpn2), .asid(wr_ent.asid), .hit(p_hit)
  );
  tlb_first #(.N(ENTRIES)) u_lfirst (.vec(l_hit), .idx(l_idx), .found(l_found));
  tlb_first #(.N(ENTRIES)) u_pfirst (.vec(p_hit), .idx(p_idx), .found(p_found));

  tlb_entry_t      sel_ent;
  tlb_half_t       sel_half;
  logic [PA_W-1:0] sel_pa;

  always_comb begin
    sel_ent  = ent[l_idx];
    sel_half = odd_select(look_va, sel_ent.mask) ? sel_ent.odd : sel_ent.even;
    sel_pa   = join_pa(sel_half.pfn, look_va, sel_ent.mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_side  <= 1'b0;
      res_miss  <= 1'b0;
      res_inval <= 1'b0;
      res_modf  <= 1'b0;
      res_attr  <= '0;
      res_pa    <= '0;
      sw_ack    <= 1'b0;
      sw_rdata  <= '0;
      sw_pnf    <= 1'b0;
      sw_pidx   <= '0;
    end else begin
      res_valid <= look_valid;
      res_side  <= look_side;
      res_miss  <= look_valid && !l_found;
      res_inval <= look_valid && l_found && !sel_half.valid;
      res_modf  <= look_valid && l_found && sel_half.valid && look_store && !sel_half.dirty;
      res_attr  <= (look_valid && l_found) ? sel_half.attr : '0;
      res_pa    <= (look_valid && l_found) ? sel_pa : '0;
      sw_ack    <= op != SW_IDLE;
      if (op == SW_READ) sw_rdata <= in_range ? ENT_W'(ent[sw_index]) : '0;
      if (op == SW_PROBE) begin
        sw_pnf  <= !p_found;
        sw_pidx <= p_idx;
      end
    end
  end
endmodule

// File: rtl/jtlb_chk.sv
module jtlb_chk
  import tlb_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            i_req,
  input logic [VA_W-1:0] i_va,
  input logic            i_gnt,
  input logic            d_req,
  input logic [VA_W-1:0] d_va,
  input logic            d_gnt,
  input logic            res_valid,
  input logic            res_side,
  input logic            res_miss,
  input logic            res_inval,
  input logic            res_modf,
  input logic [PA_W-1:0] res_pa,
  input logic [1:0]      sw_op,
  input logic            sw_ack
);
  AST_GNT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(i_gnt && d_gnt)); // R8
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (rst)
    d_req |-> (d_gnt && !i_gnt)); // R8
  AST_SIDE_DATA: assert property (@(posedge clk) disable iff (rst)
    d_req |=> res_side); // R8
  AST_RES_NEXT: assert property (@(posedge clk) disable iff (rst)
    (i_req || d_req) |=> res_valid); // R11
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(i_req || d_req) |=> !res_valid); // R11
  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot0({res_miss, res_inval, res_modf})); // R7
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_miss || res_inval || res_modf)); // R6
  AST_FETCH_NO_MODF: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_side) |-> !res_modf); // R7
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_miss) |->
      (res_pa[PG_W-1:0] == $past(d_req ? d_va[PG_W-1:0] : i_va[PG_W-1:0]))); // R4
  AST_SW_ACK: assert property (@(posedge clk) disable iff (rst)
    (sw_op != 2'd0) |=> sw_ack); // R9
  AST_SW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sw_op == 2'd0) |=> !sw_ack); // R9
endmodule

bind jtlb jtlb_chk u_chk (
  .clk(clk), .rst(rst), .i_req(i_req), .i_va(i_va), .i_gnt(i_gnt),
  .d_req(d_req), .d_va(d_va), .d_gnt(d_gnt), .res_valid(res_valid),
  .res_side(res_side), .res_miss(res_miss), .res_inval(res_inval),
  .res_modf(res_modf), .res_pa(res_pa), .sw_op(sw_op), .sw_ack(sw_ack)
);

// File: tb/tb_jtlb.sv
module tb_jtlb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        i_req = 1'b0, d_req = 1'b0, d_store = 1'b0;
  logic [31:0] i_va = '0, d_va = '0;
  logic [7:0]  cur_asid = '0;
  logic        i_gnt, d_gnt;
  logic        res_valid, res_side, res_miss, res_inval, res_modf;
  logic [2:0]  res_attr;
  logic [35:0] res_pa;
  logic [1:0]  sw_op = '0;
  logic [5:0]  sw_index = '0;
  logic [97:0] sw_wdata = '0;
  logic        sw_ack, sw_pnf;
  logic [97:0] sw_rdata;
  logic [5:0]  sw_pidx;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  jtlb dut (
    .clk(clk), .rst(rst), .i_req(i_req), .i_va(i_va), .i_gnt(i_gnt),
    .d_req(d_req), .d_va(d_va), .d_store(d_store), .d_gnt(d_gnt),
    .cur_asid(cur_asid), .res_valid(res_valid), .res_side(res_side),
    .res_miss(res_miss), .res_inval(res_inval), .res_modf(res_modf),
    .res_attr(res_attr), .res_pa(res_pa), .sw_op(sw_op), .sw_index(sw_index),
    .sw_wdata(sw_wdata), .sw_ack(sw_ack), .sw_rdata(sw_rdata),
    .sw_pnf(sw_pnf), .sw_pidx(sw_pidx)
  );

  typedef struct packed {
    logic        side;
    logic [31:0] va;
    logic [7:0]  asid;
    logic        st;
    logic        miss;
    logic        inval;
    logic        modf;
    logic [2:0]  attr;
    logic [35:0] pa;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h00400ABC, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 36'h000123ABC}, // R2 even 4KB
    '{1'b1, 32'h00401ABC, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 36'h000456ABC}, // R3 odd 4KB
    '{1'b1, 32'h00401ABC, 8'h05, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 36'h000456ABC}, // R7 clean store
    '{1'b1, 32'h00400ABC, 8'h06, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 36'h000000000}, // R2 asid miss
    '{1'b0, 32'h10002345, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 36'h0ABCD2345}, // R4 16KB global
    '{1'b1, 32'h10004000, 8'h05, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 36'h000000000}, // R6 invalid half
    '{1'b0, 32'h81234567, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 36'h200234567}, // R3 16MB odd
    '{1'b1, 32'h80234567, 8'h05, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 36'h100234567}, // R7 dirty store
    '{1'b1, 32'h82000000, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 36'h000000000}, // R6 miss
    '{1'b0, 32'h00600010, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 36'h000AAA010}, // R5 lowest index
    '{1'b0, 32'h00400ABC, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 36'h000123ABC}  // R8 fetch side
  };

  function automatic logic [28:0] half(input logic [23:0] pfn, input logic [2:0] attr,
                                       input logic d, input logic v);
    return {pfn, attr, d, v};
  endfunction

  function automatic logic [97:0] entry(input logic [18:0] vpn2, input logic [11:0] mask,
                                        input logic [7:0] asid, input logic g,
                                        input logic [28:0] odd, input logic [28:0] even);
    return {vpn2, mask, asid, g, odd, even};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic side, input logic [31:0] va, input logic [7:0] asid,
                        input logic st);
    @(negedge clk);
    cur_asid = asid;
    if (side) begin d_req = 1'b1; d_va = va; d_store = st; end
    else      begin i_req = 1'b1; i_va = va; end
    @(negedge clk);
    d_req = 1'b0; i_req = 1'b0; d_store = 1'b0;
  endtask

  task automatic sw(input logic [1:0] op, input logic [5:0] idx, input logic [97:0] data);
    @(negedge clk);
    sw_op = op; sw_index = idx; sw_wdata = data;
    @(negedge clk);
    sw_op = 2'd0;
  endtask

  logic [97:0] e2_word;

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: outputs cleared by reset
    chk(!res_valid && !sw_ack && res_pa == '0, "R1 reset outputs",
        {res_valid, sw_ack, res_pa}, 0);
    // R1: cleared entries never match a nonzero ASID
    lookup(1'b1, 32'h00000000, 8'h05, 1'b0);
    chk(res_valid && res_miss && !res_inval, "R1 cleared miss", {res_miss, res_inval}, 2'b10);
    // R1: cleared entries match VPN2 0 / ASID 0 but both halves are invalid
    lookup(1'b1, 32'h00000000, 8'h00, 1'b0);
    chk(res_valid && !res_miss && res_inval, "R1 cleared invalid", {res_miss, res_inval}, 2'b01);

    // load the table
    sw(2'd1, 6'd0, entry(19'h00200, 12'h000, 8'h05, 1'b0,
                         half(24'h000456, 3'd2, 1'b0, 1'b1), half(24'h000123, 3'd3, 1'b1, 1'b1)));
    chk(sw_ack == 1'b1, "R9 write ack", sw_ack, 1);
    sw(2'd1, 6'd1, entry(19'h08000, 12'h003, 8'h22, 1'b1,
                         half(24'h000000, 3'd0, 1'b0, 1'b0), half(24'h0ABCD0, 3'd5, 1'b1, 1'b1)));
    e2_word = entry(19'h40000, 12'hFFF, 8'h05, 1'b0,
                    half(24'h200000, 3'd3, 1'b1, 1'b1), half(24'h100000, 3'd2, 1'b1, 1'b1));
    sw(2'd1, 6'd2, e2_word);
    sw(2'd1, 6'd10, entry(19'h00300, 12'h000, 8'h05, 1'b0,
                          half(24'h0, 3'd0, 1'b0, 1'b0), half(24'h000BBB, 3'd4, 1'b1, 1'b1)));
    sw(2'd1, 6'd7, entry(19'h00300, 12'h000, 8'h05, 1'b0,
                         half(24'h0, 3'd0, 1'b0, 1'b0), half(24'h000AAA, 3'd1, 1'b1, 1'b1)));

    // R9: indexed read returns the whole word
    sw(2'd2, 6'd2, '0);
    chk(sw_rdata == e2_word, "R9 read back", sw_rdata, e2_word);

    // table walk (R2 R3 R4 R5 R6 R7 R8 R11)
    for (int k = 0; k < NV; k++) begin
      lookup(VECS[k].side, VECS[k].va, VECS[k].asid, VECS[k].st);
      chk(res_valid && res_side == VECS[k].side && res_miss == VECS[k].miss &&
          res_inval == VECS[k].inval && res_modf == VECS[k].modf &&
          (VECS[k].miss || (res_pa == VECS[k].pa && res_attr == VECS[k].attr)),
          $sformatf("R11 vector %0d", k),
          {res_valid, res_side, res_miss, res_inval, res_modf, res_attr, res_pa},
          {1'b1, VECS[k].side, VECS[k].miss, VECS[k].inval, VECS[k].modf,
           VECS[k].attr, VECS[k].pa});
    end

    // R10: probe hits, global probe and not-found
    sw(2'd3, 6'd0, entry(19'h00200, 12'h0, 8'h05, 1'b0, '0, '0));
    chk(!sw_pnf && sw_pidx == 6'd0, "R10 probe entry 0", {sw_pnf, sw_pidx}, 7'd0);
    sw(2'd3, 6'd0, entry(19'h08001, 12'h0, 8'h09, 1'b0, '0, '0));
    chk(!sw_pnf && sw_pidx == 6'd1, "R10 probe global", {sw_pnf, sw_pidx}, 7'd1);
    sw(2'd3, 6'd0, entry(19'h00999, 12'h0, 8'h05, 1'b0, '0, '0));
    chk(sw_pnf, "R10 probe not found", sw_pnf, 1);
    // R5: probe reports the lowest of two matching indices
    sw(2'd3, 6'd0, entry(19'h00300, 12'h0, 8'h05, 1'b0, '0, '0));
    chk(!sw_pnf && sw_pidx == 6'd7, "R5 probe lowest", {sw_pnf, sw_pidx}, 7'd7);

    // R8: simultaneous requests, data wins
    @(negedge clk);
    cur_asid = 8'h05;
    i_req = 1'b1; i_va = 32'h00400ABC;
    d_req = 1'b1; d_va = 32'h80234567; d_store = 1'b0;
    #1;
    chk(d_gnt && !i_gnt, "R8 grants", {d_gnt, i_gnt}, 2'b10);
    @(negedge clk);
    i_req = 1'b0; d_req = 1'b0;
    chk(res_side && res_pa == 36'h100234567, "R8 data result", {res_side, res_pa},
        {1'b1, 36'h100234567});
    @(negedge clk);
    i_req = 1'b1;
    #1;
    chk(i_gnt && !d_gnt, "R8 fetch alone", {i_gnt, d_gnt}, 2'b10);
    @(negedge clk);
    i_req = 1'b0;

    // R11: rewrite then lookup on the very next cycle
    @(negedge clk);
    sw_op = 2'd1; sw_index = 6'd0;
    sw_wdata = entry(19'h00200, 12'h000, 8'h05, 1'b0,
                     half(24'h000456, 3'd2, 1'b0, 1'b1), half(24'h000777, 3'd6, 1'b1, 1'b1));
    @(negedge clk);
    sw_op = 2'd0;
    d_req = 1'b1; d_va = 32'h00400ABC; d_store = 1'b0;
    @(negedge clk);
    d_req = 1'b0;
    chk(res_pa == 36'h000777ABC && res_attr == 3'd6, "R11 write then lookup",
        {res_attr, res_pa}, {3'd6, 36'h000777ABC});

    // R1: reset empties the table again
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    lookup(1'b1, 32'h00400ABC, 8'h05, 1'b0);
    chk(res_valid && res_miss, "R1 table cleared", res_miss, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule